// File: doc/BRIEF.md
# Packed Single-Precision Element Insert and Half-Move Unit

This unit is one registered stage of a 128-bit vector datapath. Each accepted operation carries a destination vector, a source vector, an 8-bit control byte and a 2-bit operation code. Both vectors hold four 32-bit lanes, and lane i sits in bits [32i+31:32i]. The code selects one of three things. The first places one source lane into the destination at a chosen position and then clears any lanes that a mask names. The second pulls the upper pair of source lanes down into the lower half. The third pushes the lower pair of source lanes up into the upper half.

Operands enter through a valid/ready handshake. The result is registered and appears on the cycle after acceptance, with its own valid flag. A result that the consumer has not taken stays frozen on the output. While it waits, no new operand is accepted.

Top module: `vec_elem_move`

## Requirements
- R1: With in_op = 0 (insert), in_imm[7:6] selects the source lane that is copied into the result.
- R2: With in_op = 0, in_imm[5:4] gives the result lane that receives the copied lane. Every other result lane equals the destination lane at the same position.
- R3: With in_op = 0, each set bit k of in_imm[3:0] forces result lane k to zero.
- R4: The zero mask is applied after the insertion, so a mask bit on the lane selected by in_imm[5:4] clears the inserted value.
- R5: With in_op = 1 (high-to-low), result lanes 0 and 1 are source lanes 2 and 3, and result lanes 2 and 3 are destination lanes 2 and 3. in_imm has no effect.
- R6: With in_op = 2 (low-to-high), result lanes 0 and 1 are destination lanes 0 and 1, and result lanes 2 and 3 are source lanes 0 and 1. in_imm has no effect.
- R7: With in_op = 3, the result equals the destination vector unchanged.
- R8: An operand is accepted on a rising edge where in_valid and in_ready are both high. Its result is on out_data with out_valid high from that edge on. If no new operand is accepted, out_valid drops after an edge where out_ready was high.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_data and out_valid hold. Otherwise in_ready is high.
- R10: While rst_n is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | 2 | Operation: 0 insert, 1 high-to-low, 2 low-to-high, 3 pass destination |
| in_imm | input | 8 | Control byte: [7:6] source lane, [5:4] target lane, [3:0] zero mask |
| in_dst | input | 128 | Destination vector |
| in_src | input | 128 | Source vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result vector |

## Verification
Some properties are checked on every clock. These are: the result holds under back-pressure, in_ready is low while stalled, out_valid follows acceptance, and out_valid clears once the result drains. For the half-move and pass-through codes, the result lanes are checked against the operands captured one cycle earlier. Lane selection by the control byte shows up only in the bench's scenarios. So do the zero mask clearing the inserted lane, the control byte having no effect in the half-move modes, and a reset that lands while a result is pending. The bench covers these with directed control bytes followed by a long random run under random back-pressure.

// File: rtl/vem_pkg.sv
package vem_pkg;
    parameter int ELEM_W   = 32;
    parameter int NUM_ELEM = 4;
    parameter int IDX_W    = $clog2(NUM_ELEM);
    parameter int VEC_W    = ELEM_W * NUM_ELEM;
    parameter int HALF_W   = VEC_W / 2;
    parameter int IMM_W    = 2 * IDX_W + NUM_ELEM;
    parameter int OP_W     = 2;

    typedef enum logic [OP_W-1:0] {
        OPC_INSERT = 2'd0,
        OPC_HI2LO  = 2'd1,
        OPC_LO2HI  = 2'd2,
        OPC_RSVD   = 2'd3
    } vem_op_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } vem_stage_t;
endpackage

// File: rtl/vem_insert.sv
module vem_insert
    import vem_pkg::*;
(
    input  logic [VEC_W-1:0] dst,
    input  logic [VEC_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    output logic [VEC_W-1:0] res
);
    logic [IDX_W-1:0]    src_sel;
    logic [IDX_W-1:0]    tgt_sel;
    logic [NUM_ELEM-1:0] zap;
    logic [ELEM_W-1:0]   src_lane [NUM_ELEM];
    logic [ELEM_W-1:0]   picked;

    assign src_sel = imm[IMM_W-1 -: IDX_W];
    assign tgt_sel = imm[NUM_ELEM +: IDX_W];
    assign zap     = imm[NUM_ELEM-1:0];

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_split
        assign src_lane[e] = src[e*ELEM_W +: ELEM_W];
    end

    assign picked = src_lane[src_sel];

    // Insertion first, then the mask wins over it.
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
        logic [ELEM_W-1:0] placed;
        assign placed = (tgt_sel == IDX_W'(e)) ? picked : dst[e*ELEM_W +: ELEM_W];
        assign res[e*ELEM_W +: ELEM_W] = zap[e] ? '0 : placed;
    end
endmodule

// File: rtl/vem_halfmove.sv
module vem_halfmove
    import vem_pkg::*;
#(
    parameter bit MOVE_DOWN = 1'b1
) (
    input  logic [HALF_W-1:0] keep_half,
    input  logic [HALF_W-1:0] moved_half,
    output logic [VEC_W-1:0]  res
);
    if (MOVE_DOWN) begin : g_down
        // moved pair lands low, kept destination pair stays high
        assign res = {keep_half, moved_half};
    end else begin : g_up
        // kept destination pair stays low, moved pair lands high
        assign res = {moved_half, keep_half};
    end
endmodule

// File: rtl/vec_elem_move.sv
module vec_elem_move
    import vem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_op,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [VEC_W-1:0] in_dst,
    input  logic [VEC_W-1:0] in_src,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data
);
    vem_stage_t       stage_d, stage_q;
    logic [VEC_W-1:0] ins_res, down_res, up_res, result;
    logic             take;
    vem_op_e          op;

    assign op = vem_op_e'(in_op);

    vem_insert u_insert (
        .dst (in_dst),
        .src (in_src),
        .imm (in_imm),
        .res (ins_res)
    );

    vem_halfmove #(.MOVE_DOWN(1'b1)) u_down (
        .keep_half  (in_dst[VEC_W-1:HALF_W]),
        .moved_half (in_src[VEC_W-1:HALF_W]),
        .res        (down_res)
    );

    vem_halfmove #(.MOVE_DOWN(1'b0)) u_up (
        .keep_half  (in_dst[HALF_W-1:0]),
        .moved_half (in_src[HALF_W-1:0]),
        .res        (up_res)
    );

    assign in_ready = !(stage_q.valid && !out_ready);
    assign take     = in_valid && in_ready;

    always_comb begin
        unique case (op)
            OPC_INSERT: result = ins_res;
            OPC_HI2LO:  result = down_res;
            OPC_LO2HI:  result = up_res;
            default:    result = in_dst;
        endcase

        stage_d = stage_q;
        if (take) begin
            stage_d.valid = 1'b1;
            stage_d.data  = result;
        end else if (out_ready) begin
            stage_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_data  = stage_q.data;
endmodule

// File: rtl/vem_checker.sv
module vem_checker
    import vem_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OP_W-1:0]  in_op,
    input logic [IMM_W-1:0] in_imm,
    input logic [VEC_W-1:0] in_dst,
    input logic [VEC_W-1:0] in_src,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_data
);
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == OPC_HI2LO) |=>
        (out_data == {$past(in_dst[VEC_W-1:HALF_W]), $past(in_src[VEC_W-1:HALF_W])}));

    p_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == OPC_LO2HI) |=>
        (out_data == {$past(in_src[HALF_W-1:0]), $past(in_dst[HALF_W-1:0])}));

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == OPC_RSVD) |=> (out_data == $past(in_dst)));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind vec_elem_move vem_checker chk_i (.*);

// File: tb/vec_elem_move_tb_top.sv
`timescale 1ns/1ps
module vec_elem_move_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_op = '0;
    logic [7:0]   in_imm = '0;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R8";

    logic         exp_valid = 1'b0;
    logic [127:0] exp_data = '0;
    string        exp_tag = "R8";
    bit           held_last = 1'b0;

    always #10 clk = ~clk;

    vec_elem_move dut_i (.*);

    function automatic logic [127:0] ref_result(input logic [1:0] op, input logic [7:0] imm,
                                                input logic [127:0] d, input logic [127:0] s);
        logic [127:0] r;
        int tgt, from;
        case (op)
            2'd0: begin
                r = d;
                tgt = int'(imm[5:4]);
                from = int'(imm[7:6]);
                r[tgt*32 +: 32] = s[from*32 +: 32];
                for (int k = 0; k < 4; k++) if (imm[k]) r[k*32 +: 32] = 32'h0;
            end
            2'd1: r = {d[127:64], s[127:64]};
            2'd2: r = {s[63:0], d[63:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    // Behavioural reference of the output stage.
    always @(posedge clk) begin
        bit ready_now;
        ready_now = !(exp_valid && !out_ready);
        held_last = exp_valid && !out_ready && rst_n;
        if (!rst_n) begin
            exp_valid = 1'b0;
        end else if (in_valid && ready_now) begin
            exp_valid = 1'b1;
            exp_data  = ref_result(in_op, in_imm, in_dst, in_src);
            exp_tag   = cur_tag;
        end else if (out_ready) begin
            exp_valid = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (out_valid !== exp_valid) begin
                n_bad++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", !rst_n ? "R10" : (held_last ? "R9" : "R8"), out_valid, exp_valid);
            end
            if (rst_n) begin
                n_vec++;
                if (in_ready !== !(exp_valid && !out_ready)) begin
                    n_bad++;
                    $display("FAIL R9 in_ready actual=%0b expected=%0b", in_ready, !(exp_valid && !out_ready));
                end
                if (exp_valid) begin
                    n_vec++;
                    if (out_data !== exp_data) begin
                        n_bad++;
                        $display("FAIL %s out_data actual=%h expected=%h", held_last ? "R9" : exp_tag, out_data, exp_data);
                    end
                end
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [7:0] imm, input logic [127:0] d,
                        input logic [127:0] s, input string tag, input int stall_pct);
        bit seen;
        @(posedge clk); #5;
        in_valid = 1'b1; in_op = op; in_imm = imm; in_dst = d; in_src = s; cur_tag = tag;
        forever begin
            out_ready = ($urandom_range(99) >= stall_pct);
            #4;
            seen = in_ready;
            @(posedge clk); #5;
            if (seen) break;
        end
        in_valid = 1'b0;
        in_dst = {4{$urandom()}};
    endtask

    task automatic idle(input int n, input int stall_pct);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #5;
            in_valid = 1'b0;
            in_src = {$urandom(), $urandom(), $urandom(), $urandom()};
            out_ready = ($urandom_range(99) >= stall_pct);
        end
    endtask

    localparam logic [127:0] D0 = 128'hD3D3D3D3_D2D2D2D2_D1D1D1D1_D0D0D0D0;
    localparam logic [127:0] S0 = 128'h53535353_52525252_51515151_50505050;

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1 R2: lane selection without masking
        send(2'd0, 8'b11_00_0000, D0, S0, "R1 R2", 0);
        send(2'd0, 8'b01_10_0000, D0, S0, "R1 R2", 0);
        send(2'd0, 8'b00_11_0000, D0, S0, "R1 R2", 0);
        send(2'd0, 8'b10_01_0000, D0, S0, "R1 R2", 0);
        // R3: masking other lanes
        send(2'd0, 8'b10_00_0110, D0, S0, "R3", 0);
        send(2'd0, 8'b00_00_1111, D0, S0, "R3", 0);
        // R4: mask clears the inserted lane
        send(2'd0, 8'b01_10_0100, D0, S0, "R4", 0);
        send(2'd0, 8'b11_01_1010, D0, S0, "R4", 0);
        // R5 R6: control byte has no effect
        send(2'd1, 8'h00, D0, S0, "R5", 0);
        send(2'd1, 8'hFF, D0, S0, "R5", 0);
        send(2'd2, 8'h00, D0, S0, "R6", 0);
        send(2'd2, 8'hFF, D0, S0, "R6", 0);
        // R7: unused code
        send(2'd3, 8'h5A, D0, S0, "R7", 0);
        idle(3, 0);
        // R9: long stall with a waiting operand
        send(2'd0, 8'b11_11_0000, D0, S0, "R9", 90);
        send(2'd1, 8'h3C, S0, D0, "R9", 90);
        idle(4, 100);
        idle(2, 0);
        // R10: reset while a result is pending
        send(2'd2, 8'h00, D0, S0, "R10", 0);
        #1 out_ready = 1'b0;
        @(posedge clk); #5 rst_n = 1'b0;
        idle(2, 100);
        @(posedge clk); #5 rst_n = 1'b1;
        idle(2, 0);
        // mixed random run with back-pressure
        for (int v = 0; v < 400; v++) begin
            logic [1:0] op;
            op = 2'($urandom_range(3));
            send(op, 8'($urandom()), {$urandom(), $urandom(), $urandom(), $urandom()},
                 {$urandom(), $urandom(), $urandom(), $urandom()},
                 op == 2'd0 ? "R1 R2 R3 R4" : op == 2'd1 ? "R5" : op == 2'd2 ? "R6" : "R7", 30);
            if (v % 7 == 0) idle(1, 50);
        end
        idle(4, 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule